// File: doc/BRIEF.md
# Boot Image Stream Loader

This block turns a serial boot image, delivered one byte at a time over a valid/ready handshake, into memory writes. Bytes are paired into 16-bit words (low byte first). The first word must be the image key. A fixed header follows: two 32-bit bus timing settings, a run of reserved words that are skipped, and a 32-bit entry point of which only 23 bits matter. After the header comes a sequence of load records. Each record gives a word count, a 32-bit destination address and that many data words. Every data word is issued on a simple write port at an address that starts at the destination and steps by one.

A record with a count of zero ends the image. The loader then holds `done` and presents the entry point and the two timing settings. Each timing setting carries a flag that says whether it differs from zero, where zero means the defaults are kept. A bad key puts the loader into a sticky fault that ignores the rest of the stream. When the write port applies backpressure, the byte input deasserts ready, so no byte is lost.

The controller walks through these states:
- ST_KEY: waits for the key word; on a match it moves to ST_NOM_HI, otherwise to ST_FAULT.
- ST_NOM_HI → ST_NOM_LO → ST_DAT_HI → ST_DAT_LO: capture the two timing values, one word each.
- ST_RSV: consumes the reserved words, then moves to ST_PC_HI.
- ST_PC_HI → ST_PC_LO: capture the entry point, then move to ST_SIZE.
- ST_SIZE: a zero count moves to ST_DONE; a nonzero count moves to ST_ADDR_HI.
- ST_ADDR_HI → ST_ADDR_LO → ST_DATA: capture the destination address, then take the data words.
- ST_DATA: returns to ST_SIZE after the last word of the record.
- ST_DONE and ST_FAULT: terminal until reset.

Top module: `boot_stream_loader`

## Requirements
- R1: Each word is built from two accepted bytes: the first byte is bits [7:0] and the second is bits [15:8]. Bytes 0xAA then 0x08 give 0x08AA, and the reverse order does not.
- R2: If the first word is not 0x08AA, `error` rises and stays high until reset. `done` stays low, no write is issued, and all later bytes are accepted and discarded.
- R3: Words 2 and 3 form `nom_timing` as {word2, word3}. `nom_custom` is 1 exactly when that 32-bit value is nonzero.
- R4: Words 4 and 5 form `dat_timing` in the same upper-then-lower order. `dat_custom` is 1 exactly when that value is nonzero.
- R5: The next four words are consumed whatever their value, and they change no output.
- R6: The following two words give `entry_pc` = {upper[6:0], lower}. Upper bits [15:7] are discarded.
- R7: Each record is a count N, then the address upper half, then the lower half, then N data words. Data word i is written to address + i, computed modulo 2^32.
- R8: A count of 0x0000 ends the image. From then until reset, `done` stays high, `entry_pc` is stable, and further bytes cause no write.
- R9: While `mem_wr_en` is high and `mem_ready` is low, `in_ready` is low, and the write address and data hold stable. Every byte is eventually written or parsed.
- R10: After reset, `in_ready`=1, `done`=0, `error`=0, `mem_wr_en`=0, and both custom flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Byte is valid |
| in_ready | output | 1 | Byte is accepted when valid and ready |
| mem_wr_en | output | 1 | Write request, held until accepted |
| mem_addr | output | 32 | Word address of the write |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Write port accepts the request |
| done | output | 1 | End marker reached |
| error | output | 1 | Key mismatch fault |
| entry_pc | output | 23 | Entry point |
| nom_timing | output | 32 | Nominal-phase timing value |
| nom_custom | output | 1 | Nominal timing is nonzero |
| dat_timing | output | 32 | Data-phase timing value |
| dat_custom | output | 1 | Data timing is nonzero |

## Verification
The bench builds the loader with its default parameters: a key of 0x08AA, four reserved words, a 32-bit address and a 23-bit entry point.

With the full 32-bit address, one record can start just below 0xFFFFFFFF and wrap to zero, and another can cross the boundary between the two address halves. Both cases are exercised.

Random gaps on the byte input and random stalls on the write port, together with byte-swapped and off-by-one keys, show ready dropping during a stall and show that the fault path ignores the rest of the stream.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
    typedef enum logic [3:0] {
        ST_KEY,
        ST_NOM_HI,
        ST_NOM_LO,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_RSV,
        ST_PC_HI,
        ST_PC_LO,
        ST_SIZE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA,
        ST_DONE,
        ST_FAULT
    } ldr_state_t;
endpackage

// File: rtl/bsl_word_pair.sv
module bsl_word_pair #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_fire,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              word_fire,
    output logic [WORD_W-1:0] word_out
);
    logic              have_lo;
    logic [BYTE_W-1:0] lo_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_lo <= 1'b0;
            lo_byte <= '0;
        end else if (byte_fire) begin
            have_lo <= !have_lo;
            if (!have_lo) lo_byte <= byte_in;
        end
    end

    // second byte completes the word: high half is the byte now arriving
    assign word_fire = byte_fire && have_lo;
    assign word_out  = {byte_in, lo_byte};
endmodule

// File: rtl/bsl_seq.sv
module bsl_seq
    import bsl_pkg::*;
#(
    parameter int          WORD_W    = 16,
    parameter logic [15:0] KEY       = 16'h08AA,
    parameter int          RSV_WORDS = 4,
    parameter int          ADDR_W    = 32,
    parameter int          PC_W      = 23,
    parameter int          TIM_W     = 32,
    localparam int         RSV_CW    = $clog2(RSV_WORDS + 1),
    localparam int         PC_HI_W   = PC_W - WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_fire,
    input  logic [WORD_W-1:0] word,
    output logic              data_fire,
    output logic [ADDR_W-1:0] data_addr,
    output logic              done,
    output logic              error,
    output logic [PC_W-1:0]   entry_pc,
    output logic [TIM_W-1:0]  nom_timing,
    output logic              nom_custom,
    output logic [TIM_W-1:0]  dat_timing,
    output logic              dat_custom
);
    ldr_state_t          state, nxt;
    logic [WORD_W-1:0]   hi_buf;
    logic [RSV_CW-1:0]   rsv_cnt;
    logic [WORD_W-1:0]   words_left;
    logic [ADDR_W-1:0]   cur_addr;
    logic [2*WORD_W-1:0] joined;

    assign joined = {hi_buf, word};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_KEY;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_KEY:     if (word_fire) nxt = (word == KEY) ? ST_NOM_HI : ST_FAULT;
            ST_NOM_HI:  if (word_fire) nxt = ST_NOM_LO;
            ST_NOM_LO:  if (word_fire) nxt = ST_DAT_HI;
            ST_DAT_HI:  if (word_fire) nxt = ST_DAT_LO;
            ST_DAT_LO:  if (word_fire) nxt = ST_RSV;
            ST_RSV:     if (word_fire && rsv_cnt == RSV_CW'(RSV_WORDS - 1)) nxt = ST_PC_HI;
            ST_PC_HI:   if (word_fire) nxt = ST_PC_LO;
            ST_PC_LO:   if (word_fire) nxt = ST_SIZE;
            ST_SIZE:    if (word_fire) nxt = (word == '0) ? ST_DONE : ST_ADDR_HI;
            ST_ADDR_HI: if (word_fire) nxt = ST_ADDR_LO;
            ST_ADDR_LO: if (word_fire) nxt = ST_DATA;
            ST_DATA:    if (word_fire && words_left == WORD_W'(1)) nxt = ST_SIZE;
            ST_DONE:    nxt = ST_DONE;
            ST_FAULT:   nxt = ST_FAULT;
            default:    nxt = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_buf     <= '0;
            rsv_cnt    <= '0;
            words_left <= '0;
            cur_addr   <= '0;
            entry_pc   <= '0;
            nom_timing <= '0;
            nom_custom <= 1'b0;
            dat_timing <= '0;
            dat_custom <= 1'b0;
        end else if (word_fire) begin
            unique case (state)
                ST_NOM_HI, ST_DAT_HI, ST_PC_HI, ST_ADDR_HI: hi_buf <= word;
                ST_NOM_LO: begin
                    nom_timing <= TIM_W'(joined);
                    nom_custom <= (joined != '0);
                end
                ST_DAT_LO: begin
                    dat_timing <= TIM_W'(joined);
                    dat_custom <= (joined != '0);
                    rsv_cnt    <= '0;
                end
                ST_RSV:     rsv_cnt    <= rsv_cnt + 1'b1;
                ST_PC_LO:   entry_pc   <= {hi_buf[PC_HI_W-1:0], word};
                ST_SIZE:    words_left <= word;
                ST_ADDR_LO: cur_addr   <= ADDR_W'(joined);
                ST_DATA: begin
                    cur_addr   <= cur_addr + 1'b1;
                    words_left <= words_left - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        data_fire = word_fire && (state == ST_DATA);
        data_addr = cur_addr;
        done      = (state == ST_DONE);
        error     = (state == ST_FAULT);
    end

    assert_fault_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (error && !done));
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(entry_pc) && $stable(nom_timing) && $stable(dat_timing)));
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_fire && words_left != WORD_W'(1)) |=> (data_addr == $past(data_addr) + 1'b1));
endmodule

// File: rtl/bsl_wr_port.sv
module bsl_wr_port #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              mem_ready,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              stall
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_wr_en <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (load) begin
            mem_wr_en <= 1'b1;
            mem_addr  <= load_addr;
            mem_wdata <= load_data;
        end else if (mem_ready) begin
            mem_wr_en <= 1'b0;
        end
    end

    assign stall = mem_wr_en && !mem_ready;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !mem_ready) |=> (mem_wr_en && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: rtl/boot_stream_loader.sv
module boot_stream_loader
    import bsl_pkg::*;
#(
    parameter int          BYTE_W    = 8,
    parameter logic [15:0] KEY       = 16'h08AA,
    parameter int          RSV_WORDS = 4,
    parameter int          ADDR_W    = 32,
    parameter int          PC_W      = 23,
    parameter int          TIM_W     = 32,
    localparam int         WORD_W    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    output logic              done,
    output logic              error,
    output logic [PC_W-1:0]   entry_pc,
    output logic [TIM_W-1:0]  nom_timing,
    output logic              nom_custom,
    output logic [TIM_W-1:0]  dat_timing,
    output logic              dat_custom
);
    logic              byte_fire;
    logic              word_fire;
    logic [WORD_W-1:0] word;
    logic              data_fire;
    logic [ADDR_W-1:0] data_addr;
    logic              stall;

    assign in_ready  = !stall;
    assign byte_fire = in_valid && in_ready;

    bsl_word_pair #(.BYTE_W(BYTE_W)) pair_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_fire (byte_fire),
        .byte_in   (in_data),
        .word_fire (word_fire),
        .word_out  (word)
    );

    bsl_seq #(
        .WORD_W    (WORD_W),
        .KEY       (KEY),
        .RSV_WORDS (RSV_WORDS),
        .ADDR_W    (ADDR_W),
        .PC_W      (PC_W),
        .TIM_W     (TIM_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_fire  (word_fire),
        .word       (word),
        .data_fire  (data_fire),
        .data_addr  (data_addr),
        .done       (done),
        .error      (error),
        .entry_pc   (entry_pc),
        .nom_timing (nom_timing),
        .nom_custom (nom_custom),
        .dat_timing (dat_timing),
        .dat_custom (dat_custom)
    );

    bsl_wr_port #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) wr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (data_fire),
        .load_addr (data_addr),
        .load_data (word),
        .mem_ready (mem_ready),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .stall     (stall)
    );

    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !mem_ready) |-> !in_ready);
    assert_no_write_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_wr_en);
    assert_no_write_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !mem_wr_en);
    assert_exclusive_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, error}));
endmodule

// File: tb/boot_stream_loader_tb.sv
module boot_stream_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  in_data;
    logic        in_valid;
    logic        in_ready;
    logic        mem_wr_en;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ready;
    logic        done;
    logic        error;
    logic [22:0] entry_pc;
    logic [31:0] nom_timing;
    logic        nom_custom;
    logic [31:0] dat_timing;
    logic        dat_custom;

    always #4 clk = ~clk;

    boot_stream_loader dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .done(done), .error(error),
        .entry_pc(entry_pc), .nom_timing(nom_timing), .nom_custom(nom_custom),
        .dat_timing(dat_timing), .dat_custom(dat_custom)
    );

    byte unsigned q[$];
    logic [47:0]  exp_wr[$];
    int    errors = 0;
    int    checks = 0;
    bit    run = 1'b0;
    int    valid_pct = 100;
    int    ready_pct = 100;
    string wr_req = "R7";

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic push_word(input logic [15:0] w);
        q.push_back(w[7:0]);
        q.push_back(w[15:8]);
    endtask

    task automatic add_record(input logic [31:0] addr, input int n,
                              input logic [15:0] base, input bit expect_it);
        push_word(16'(n));
        push_word(addr[31:16]);
        push_word(addr[15:0]);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a;
            logic [15:0] d;
            a = addr + 32'(i);
            d = base + 16'(i * 3);
            push_word(d);
            if (expect_it) exp_wr.push_back({a, d});
        end
    endtask

    task automatic header(input logic [31:0] nom, input logic [31:0] dat,
                          input logic [15:0] r0, input logic [15:0] r1,
                          input logic [31:0] pc);
        push_word(16'h08AA);
        push_word(nom[31:16]); push_word(nom[15:0]);
        push_word(dat[31:16]); push_word(dat[15:0]);
        push_word(r0); push_word(r1); push_word(r1); push_word(r0);
        push_word(pc[31:16]); push_word(pc[15:0]);
    endtask

    task automatic do_reset();
        run = 1'b0;
        q.delete();
        exp_wr.delete();
        valid_pct = 100;
        ready_pct = 100;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic drain();
        run = 1'b1;
        while (q.size() > 0) @(negedge clk);
        ready_pct = 100;
        repeat (8) @(negedge clk);
        check(wr_req, "pending expected writes", 64'(exp_wr.size()), 64'd0);
    endtask

    // driver: new stimulus at every falling edge
    always @(negedge clk) begin
        if (run && q.size() > 0 && $urandom_range(99) < valid_pct) begin
            in_valid = 1'b1;
            in_data  = q[0];
        end else begin
            in_valid = 1'b0;
            in_data  = 8'h00;
        end
        mem_ready = ($urandom_range(99) < ready_pct);
    end

    // reference model: byte queue and expected write queue, compared every clock
    always @(negedge clk) begin
        #1;
        if (rst_n === 1'b1) begin
            if (in_valid && in_ready) void'(q.pop_front());
            if (mem_wr_en && !mem_ready) begin
                check("R9", "in_ready during stall", 64'(in_ready), 64'd0);
            end
            if (mem_wr_en && mem_ready) begin
                if (exp_wr.size() == 0) begin
                    check(wr_req, "unexpected write addr", 64'(mem_addr), 64'hFFFF_FFFF_FFFF);
                end else begin
                    check(wr_req, "write addr", 64'(mem_addr), 64'(exp_wr[0][47:16]));
                    check(wr_req, "write data", 64'(mem_wdata), 64'(exp_wr[0][15:0]));
                    void'(exp_wr.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; mem_ready = 1'b1;
        do_reset();

        // R10 reset state
        check("R10", "in_ready", 64'(in_ready), 64'd1);
        check("R10", "done", 64'(done), 64'd0);
        check("R10", "error", 64'(error), 64'd0);
        check("R10", "mem_wr_en", 64'(mem_wr_en), 64'd0);
        check("R10", "custom flags", 64'({nom_custom, dat_custom}), 64'd0);

        // Image A: clean flow, only upper half of nominal timing set, carry across halves
        wr_req = "R7";
        header(32'h0001_0000, 32'h0000_0000, 16'h0000, 16'h0000, 32'hFF12_3456);
        add_record(32'h0001_0000, 3, 16'h1000, 1'b1);
        add_record(32'h8000_FFFF, 2, 16'hBEEF, 1'b1);
        push_word(16'h0000);
        drain();
        check("R8", "done A", 64'(done), 64'd1);
        check("R2", "error A", 64'(error), 64'd0);
        check("R6", "entry_pc A upper bits dropped", 64'(entry_pc), 64'h12_3456);
        check("R3", "nom_timing A", 64'(nom_timing), 64'h0001_0000);
        check("R3", "nom_custom A", 64'(nom_custom), 64'd1);
        check("R4", "dat_timing A", 64'(dat_timing), 64'd0);
        check("R4", "dat_custom A zero", 64'(dat_custom), 64'd0);

        // Image B: gaps and stalls, nonzero reserved words, address wrap, post-end bytes
        do_reset();
        valid_pct = 60; ready_pct = 40; wr_req = "R9";
        header(32'hAABB_CCDD, 32'h1122_3344, 16'hFFFF, 16'h5A5A, 32'h007F_0001);
        add_record(32'hFFFF_FFFE, 5, 16'h2000, 1'b1);
        add_record(32'h0000_0100, 1, 16'h7777, 1'b1);
        push_word(16'h0000);
        drain();
        check("R8", "done B", 64'(done), 64'd1);
        check("R5", "reserved words no effect on pc", 64'(entry_pc), 64'h7F_0001);
        check("R3", "nom_timing B", 64'(nom_timing), 64'hAABB_CCDD);
        check("R3", "nom_custom B", 64'(nom_custom), 64'd1);
        check("R4", "dat_timing B", 64'(dat_timing), 64'h1122_3344);
        check("R4", "dat_custom B", 64'(dat_custom), 64'd1);
        // R8: bytes after the end marker produce no write and change nothing
        wr_req = "R8";
        add_record(32'h0000_0040, 2, 16'h3333, 1'b0);
        drain();
        check("R8", "done held", 64'(done), 64'd1);
        check("R8", "entry_pc held", 64'(entry_pc), 64'h7F_0001);
        check("R8", "in_ready after end", 64'(in_ready), 64'd1);

        // Image C: key bytes in swapped order -> 0xAA08, a fault (R1, R2)
        do_reset();
        wr_req = "R2";
        q.push_back(8'h08); q.push_back(8'hAA);
        push_word(16'h0000); push_word(16'h0000);
        add_record(32'h0000_0010, 3, 16'h4444, 1'b0);
        push_word(16'h0000);
        drain();
        check("R1", "swapped key gives fault", 64'(error), 64'd1);
        check("R2", "done after fault", 64'(done), 64'd0);
        check("R2", "entry_pc untouched", 64'(entry_pc), 64'd0);

        // Image D: key off by one, full valid-looking rest, stalls active
        do_reset();
        ready_pct = 50; wr_req = "R2";
        push_word(16'h08AB);
        push_word(16'h0000); push_word(16'h0001);
        push_word(16'h0000); push_word(16'h0000);
        for (int i = 0; i < 6; i++) push_word(16'h0000);
        add_record(32'h0000_0020, 2, 16'h5555, 1'b0);
        push_word(16'h0000);
        drain();
        check("R2", "error D", 64'(error), 64'd1);
        check("R2", "done D", 64'(done), 64'd0);
        check("R2", "nom_custom untouched D", 64'(nom_custom), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule